// File: doc/BRIEF.md
# Byte-Writable Data Cache Controller

This block is a direct-mapped data cache placed between a core load/store port and a word-addressed external memory bus. A request that hits returns its result one cycle after acceptance. Loads return a zero-extended byte, halfword or word. Stores change only the byte lanes they cover. Each request carries its own cache-inhibited attribute. Inhibited requests skip the array and become a single memory transfer, and they never allocate a line.

The write policy is write-through without write-allocate. Every valid store produces one memory write. A store that hits also merges into the array. A cachable load miss fetches the whole eight-word line with eight sequential single-word transfers, starting at the first word of the line. With the defaults (32-bit byte address, 256 lines of eight words, 8 KB) the byte address splits into word offset bits [4:2], line index bits [12:5] and tag bits [31:13].

The memory bus uses a hold-until-acknowledge handshake: one `mem_ack` pulse completes one word. While any memory transfer is outstanding the core port stalls.

Top module: `dcache_bw`

## Requirements
- R1: A cachable load that hits gives `rsp_valid` with `rsp_err` low exactly one cycle after acceptance, and `req_ready` stays high.
- R2: `req_size` 0 selects a byte, 1 a halfword and 2 a word. Byte lane k of a word is bits [8k+7:8k], where k comes from address bits [1:0]. The loaded value sits in the low bits of `rsp_rdata` and is zero-extended.
- R3: A store takes its value from the low bits of `req_wdata` and changes only the covered lanes: one lane for a byte, two for a halfword, four for a word. `mem_be` marks those same lanes and `mem_wdata` carries the value in them.
- R4: A cachable load miss reads eight consecutive word addresses starting at the line base. It then validates the line under the new tag and responds one cycle after the eighth acknowledge.
- R5: An inhibited load makes exactly one memory read of the addressed word and responds one cycle after its acknowledge. No line is allocated, so a later cachable load to that address misses.
- R6: Every valid store makes exactly one memory write. A store hit also updates the array and responds one cycle after acceptance. A store miss or inhibited store leaves the array alone and responds one cycle after the acknowledge. Store responses carry data 0.
- R7: `req_ready` is low exactly while a memory transfer is outstanding. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.
- R8: A halfword at an odd address, a word not 4-byte aligned, or size 3 gives `rsp_valid` with `rsp_err` high and data 0 one cycle later. It causes no memory transfer and no change to the array or memory.
- R9: A high `flush` at a clock edge invalidates every line, so the next cachable load to any address misses.
- R10: After reset `req_ready` is high, `rsp_valid` and `mem_req` are low, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all lines at this edge |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_we | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store value in the low bits |
| req_inhibit | input | 1 | Access bypasses the array |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Misaligned or reserved-size request |
| rsp_rdata | output | 32 | Zero-extended load data |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 30 | Memory word address |
| mem_be | output | 4 | Byte enables of a write |
| mem_wdata | output | 32 | Write data, lane aligned |
| mem_ack | input | 1 | Completes the current transfer |
| mem_rdata | input | 32 | Read data valid with mem_ack |

## Verification
There are two timings for a result. Hit loads, store hits and rejected misaligned requests are due one cycle after the edge that accepts them. Fill, bypass and store-miss results are due one cycle after the edge that takes the last needed `mem_ack`, and `req_ready` comes back high in that same cycle. The bench model records that due cycle when it issues the request or gives the final acknowledge. At every falling edge it compares `rsp_valid`, `req_ready` and `mem_req` with what the model expects for that cycle. Each memory transfer's address, direction and enabled lanes are checked as the model acknowledges it.

// File: rtl/dc_pkg.sv
`timescale 1ns/1ps
package dc_pkg;

   localparam int unsigned WORD_BYTES = 4;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } dc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WRITE = 2'd2,
      ST_BYPRD = 2'd3
   } dc_state_e;

   // alignment rule shared by the controller
   function automatic logic is_misaligned(input logic [1:0] size, input logic [1:0] off);
      case (dc_size_e'(size))
         SZ_BYTE: is_misaligned = 1'b0;
         SZ_HALF: is_misaligned = off[0];
         SZ_WORD: is_misaligned = (off != 2'd0);
         default: is_misaligned = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/dc_load_align.sv
`timescale 1ns/1ps
module dc_load_align
   import dc_pkg::*;
(
   input  logic [31:0] word_i,
   input  logic [1:0]  off_i,
   input  logic [1:0]  size_i,
   output logic [31:0] data_o
);
   logic [31:0] shifted;

   assign shifted = word_i >> {off_i, 3'b000};

   always_comb begin
      case (dc_size_e'(size_i))
         SZ_BYTE: data_o = {24'b0, shifted[7:0]};
         SZ_HALF: data_o = {16'b0, shifted[15:0]};
         default: data_o = shifted;
      endcase
   end
endmodule

// File: rtl/dc_lane_merge.sv
`timescale 1ns/1ps
module dc_lane_merge
   import dc_pkg::*;
(
   input  logic [1:0]  size_i,
   input  logic [1:0]  off_i,
   input  logic [31:0] wdata_i,
   input  logic [31:0] old_i,
   output logic [3:0]  be_o,
   output logic [31:0] lane_o,
   output logic [31:0] merged_o
);
   always_comb begin
      case (dc_size_e'(size_i))
         SZ_BYTE: be_o = 4'b0001 << off_i;
         SZ_HALF: be_o = 4'b0011 << off_i;
         default: be_o = 4'b1111;
      endcase
   end

   assign lane_o = wdata_i << {off_i, 3'b000};

   for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
      assign merged_o[8*b +: 8] = be_o[b] ? lane_o[8*b +: 8] : old_i[8*b +: 8];
   end
endmodule

// File: rtl/dc_tag_store.sv
`timescale 1ns/1ps
module dc_tag_store #(
   parameter int unsigned NUM_LINES = 256,
   parameter int unsigned TAG_W     = 19,
   localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             rd_valid_o,
   output logic [TAG_W-1:0] rd_tag_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [TAG_W-1:0] wr_tag_i
);
   logic [NUM_LINES-1:0] valid_q;
   logic [TAG_W-1:0]     tag_q [NUM_LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        valid_q <= '0;
      else if (flush_i)  valid_q <= '0;
      else if (wr_en_i)  valid_q[wr_idx_i] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
   end

   assign rd_valid_o = valid_q[rd_idx_i];
   assign rd_tag_o   = tag_q[rd_idx_i];

   assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (valid_q == '0));
endmodule

// File: rtl/dcache_bw.sv
`timescale 1ns/1ps
module dcache_bw
   import dc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_WORDS = 8,
   parameter int unsigned NUM_LINES  = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic              req_inhibit,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-3:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   localparam int unsigned OFF_W   = $clog2(LINE_WORDS);
   localparam int unsigned IDX_W   = $clog2(NUM_LINES);
   localparam int unsigned TAG_W   = ADDR_W - 2 - OFF_W - IDX_W;
   localparam int unsigned WADDR_W = ADDR_W - 2;
   localparam int unsigned DEPTH   = LINE_WORDS * NUM_LINES;
   localparam logic [OFF_W-1:0] LAST_W = OFF_W'(LINE_WORDS - 1);

   if ((1 << OFF_W) != LINE_WORDS || (1 << IDX_W) != NUM_LINES || OFF_W < 1
       || ADDR_W < (OFF_W + IDX_W + 3)) begin : g_bad_cfg
      $error("dcache_bw: line words and line count must be powers of two and fit the address");
   end

   dc_state_e          state_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [1:0]         size_q;
   logic [3:0]         be_q;
   logic [31:0]        wlane_q;
   logic               late_q;
   logic [OFF_W-1:0]   cnt_q;
   logic [31:0]        hold_q;
   logic [31:0]        data_q [DEPTH];

   // request decode
   logic [OFF_W-1:0] req_woff, woff_q;
   logic [IDX_W-1:0] req_idx, idx_q;
   logic [TAG_W-1:0] req_tag, tag_q, look_tag;
   logic             look_valid, hit, bad, accept;
   logic [31:0]      arr_word, hit_data, ret_word, ret_data, mrg_word, mrg_lane;
   logic [3:0]       mrg_be;

   assign req_woff = req_addr[OFF_W+1:2];
   assign req_idx  = req_addr[OFF_W+2 +: IDX_W];
   assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
   assign woff_q   = addr_q[OFF_W+1:2];
   assign idx_q    = addr_q[OFF_W+2 +: IDX_W];
   assign tag_q    = addr_q[ADDR_W-1 -: TAG_W];

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign bad       = is_misaligned(req_size, req_addr[1:0]);
   assign hit       = look_valid && (look_tag == req_tag);
   assign arr_word  = data_q[{req_idx, req_woff}];

   logic fill_done;
   assign fill_done = (state_q == ST_FILL) && mem_ack && (cnt_q == LAST_W);

   dc_tag_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush),
      .rd_idx_i   (req_idx),
      .rd_valid_o (look_valid),
      .rd_tag_o   (look_tag),
      .wr_en_i    (fill_done),
      .wr_idx_i   (idx_q),
      .wr_tag_i   (tag_q)
   );

   dc_load_align u_hit_align (
      .word_i (arr_word),
      .off_i  (req_addr[1:0]),
      .size_i (req_size),
      .data_o (hit_data)
   );

   // the last fill beat carries the target only when it is the final word
   assign ret_word = ((state_q == ST_FILL) && (woff_q != cnt_q)) ? hold_q : mem_rdata;

   dc_load_align u_ret_align (
      .word_i (ret_word),
      .off_i  (addr_q[1:0]),
      .size_i (size_q),
      .data_o (ret_data)
   );

   dc_lane_merge u_merge (
      .size_i   (req_size),
      .off_i    (req_addr[1:0]),
      .wdata_i  (req_wdata),
      .old_i    (arr_word),
      .be_o     (mrg_be),
      .lane_o   (mrg_lane),
      .merged_o (mrg_word)
   );

   // data array: one write port shared by store hits and fill beats
   always_ff @(posedge clk) begin
      if (accept && req_we && !req_inhibit && !bad && hit)
         data_q[{req_idx, req_woff}] <= mrg_word;
      else if ((state_q == ST_FILL) && mem_ack)
         data_q[{idx_q, cnt_q}] <= mem_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         size_q    <= '0;
         be_q      <= '0;
         wlane_q   <= '0;
         late_q    <= 1'b0;
         cnt_q     <= '0;
         hold_q    <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         case (state_q)
            ST_IDLE: if (req_valid) begin
               addr_q  <= req_addr;
               size_q  <= req_size;
               be_q    <= mrg_be;
               wlane_q <= mrg_lane;
               cnt_q   <= '0;
               if (bad) begin
                  rsp_valid <= 1'b1;
                  rsp_err   <= 1'b1;
                  rsp_rdata <= '0;
               end else if (!req_we) begin
                  if (req_inhibit)  state_q <= ST_BYPRD;
                  else if (hit) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= hit_data;
                  end else          state_q <= ST_FILL;
               end else begin
                  state_q <= ST_WRITE;
                  late_q  <= req_inhibit || !hit;
                  if (!req_inhibit && hit) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= '0;
                  end
               end
            end
            ST_FILL: if (mem_ack) begin
               if (cnt_q == woff_q) hold_q <= mem_rdata;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_W) begin
                  state_q   <= ST_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_rdata <= ret_data;
               end
            end
            ST_WRITE: if (mem_ack) begin
               state_q <= ST_IDLE;
               if (late_q) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= '0;
               end
            end
            ST_BYPRD: if (mem_ack) begin
               state_q   <= ST_IDLE;
               rsp_valid <= 1'b1;
               rsp_rdata <= ret_data;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_WRITE);
   assign mem_addr  = (state_q == ST_FILL) ? {addr_q[ADDR_W-1:OFF_W+2], cnt_q}
                                           : addr_q[ADDR_W-1:2];
   assign mem_be    = (state_q == ST_WRITE) ? be_q : 4'hF;
   assign mem_wdata = wlane_q;

   assert_hit_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_we && !req_inhibit && !bad && hit) |=> (rsp_valid && !rsp_err && req_ready));

   assert_fill_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_FILL) && mem_ack && (cnt_q != LAST_W))
         |=> (mem_req && (mem_addr == WADDR_W'($past(mem_addr) + 1'b1))));

   assert_hold_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && bad) |=> (rsp_valid && rsp_err && !mem_req));

   assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);
endmodule

// File: tb/dcache_bw_test.sv
`timescale 1ns/1ps
module dcache_bw_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_we = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_inhibit = 1'b0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic        mem_req, mem_we;
   logic [29:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #4 clk = ~clk;

   dcache_bw uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_inhibit(req_inhibit),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // reference state
   logic [31:0] phys  [logic [29:0]];
   logic [31:0] refm  [logic [29:0]];
   bit          mvalid [256];
   logic [18:0] mtag   [256];

   int nchk = 0, nbad = 0, cyc = 0;
   int due_at = -1, ready_at = -1, acks_left = 0, ack_no = 0, wait_cnt = 0, lat = 1;
   bit busy = 0, rsp_on_done = 0, exp_fill = 0, exp_we = 0, exp_err = 0, done = 0;
   logic [31:0] exp_data = '0, exp_wlane = '0;
   logic [3:0]  exp_be = '0;
   logic [29:0] exp_base = '0;
   string cur_tag = "R10";

   function automatic logic [31:0] seedv(logic [29:0] a);
      return ({2'b0, a} * 32'h9E3779B1) ^ 32'h00C0FFEE;
   endfunction
   function automatic logic [31:0] rd_phys(logic [29:0] a);
      return phys.exists(a) ? phys[a] : seedv(a);
   endfunction
   function automatic logic [31:0] rd_ref(logic [29:0] a);
      return refm.exists(a) ? refm[a] : seedv(a);
   endfunction
   function automatic logic [31:0] bext(logic [31:0] w, logic [1:0] off, logic [1:0] sz);
      logic [31:0] s = w >> (8 * off);
      if (sz == 2'd0) return s & 32'hFF;
      if (sz == 2'd1) return s & 32'hFFFF;
      return s;
   endfunction
   function automatic logic [31:0] lmask(logic [3:0] be);
      logic [31:0] m = '0;
      for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = 8'hFF;
      return m;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // one falling edge: compare outputs, then act as the memory
   task automatic step();
      @(negedge clk);
      cyc++;
      if (busy && cyc == ready_at) busy = 0;
      chk(rsp_valid == (due_at == cyc), cur_tag, "rsp_valid timing", {31'b0, rsp_valid},
          {31'b0, due_at == cyc});
      if (rsp_valid && due_at == cyc) begin
         chk(rsp_rdata == exp_data, cur_tag, "rsp_rdata", rsp_rdata, exp_data);
         chk(rsp_err == exp_err, cur_tag, "rsp_err", {31'b0, rsp_err}, {31'b0, exp_err});
      end
      chk(req_ready == !busy, "R7", "req_ready", {31'b0, req_ready}, {31'b0, !busy});
      chk(mem_req == busy, "R7", "mem_req", {31'b0, mem_req}, {31'b0, busy});
      if (mem_ack) begin
         mem_ack  = 1'b0;
         wait_cnt = 0;
      end else if (mem_req && busy) begin
         wait_cnt++;
         if (wait_cnt >= lat) begin
            logic [29:0] ea = exp_fill ? (exp_base + 30'(ack_no)) : exp_base;
            chk(mem_addr == ea, cur_tag, "mem_addr", {2'b0, mem_addr}, {2'b0, ea});
            chk(mem_we == exp_we, cur_tag, "mem_we", {31'b0, mem_we}, {31'b0, exp_we});
            if (mem_we) begin
               logic [31:0] w = rd_phys(mem_addr);
               chk(mem_be == exp_be, "R3", "mem_be", {28'b0, mem_be}, {28'b0, exp_be});
               chk((mem_wdata & lmask(exp_be)) == (exp_wlane & lmask(exp_be)), "R3",
                   "mem_wdata", mem_wdata & lmask(exp_be), exp_wlane & lmask(exp_be));
               phys[mem_addr] = (w & ~lmask(mem_be)) | (mem_wdata & lmask(mem_be));
            end else begin
               mem_rdata = rd_phys(mem_addr);
            end
            mem_ack = 1'b1;
            ack_no++;
            acks_left--;
            if (acks_left == 0) begin
               ready_at = cyc + 1;
               if (rsp_on_done) due_at = cyc + 1;
            end
         end
      end
   endtask

   task automatic req(bit we, logic [1:0] sz, logic [31:0] a, logic [31:0] wd, bit inh, string tag);
      logic [1:0]  off = a[1:0];
      logic [29:0] wa = a[31:2];
      logic [7:0]  idx = a[12:5];
      bit badr = (sz == 2'd3) || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0);
      bit hitm;
      while (busy) step();
      hitm = mvalid[idx] && (mtag[idx] == a[31:13]);
      req_valid = 1'b1; req_we = we; req_size = sz; req_addr = a;
      req_wdata = wd; req_inhibit = inh;
      cur_tag = tag; ack_no = 0; exp_err = 0; exp_data = '0;
      if (badr) begin
         due_at = cyc + 1; exp_err = 1;
      end else if (!we) begin
         exp_data = bext(rd_ref(wa), off, sz);
         exp_we = 0;
         if (inh) begin
            busy = 1; acks_left = 1; rsp_on_done = 1; exp_fill = 0; exp_base = wa;
         end else if (hitm) begin
            due_at = cyc + 1;
         end else begin
            busy = 1; acks_left = 8; rsp_on_done = 1; exp_fill = 1;
            exp_base = {wa[29:3], 3'b000};
            mvalid[idx] = 1; mtag[idx] = a[31:13];
         end
      end else begin
         logic [31:0] w = rd_ref(wa);
         exp_be = (sz == 2'd0) ? (4'b0001 << off) : (sz == 2'd1) ? (4'b0011 << off) : 4'hF;
         exp_wlane = wd << (8 * off);
         refm[wa] = (w & ~lmask(exp_be)) | (exp_wlane & lmask(exp_be));
         busy = 1; acks_left = 1; exp_we = 1; exp_fill = 0; exp_base = wa;
         if (!inh && hitm) begin
            due_at = cyc + 1; rsp_on_done = 0;
         end else rsp_on_done = 1;
      end
      step();
      req_valid = 1'b0;
   endtask

   task automatic do_flush();
      while (busy) step();
      flush = 1'b1;
      for (int i = 0; i < 256; i++) mvalid[i] = 0;
      step();
      flush = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL R7 watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed = 32'h1234_5678;
      for (int i = 0; i < 256; i++) mvalid[i] = 0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk(req_ready == 1'b1, "R10", "ready after reset", {31'b0, req_ready}, 32'd1);
      chk(rsp_valid == 1'b0, "R10", "rsp after reset", {31'b0, rsp_valid}, 32'd0);
      chk(mem_req == 1'b0, "R10", "mem_req after reset", {31'b0, mem_req}, 32'd0);

      lat = 1;
      req(0, 2'd2, 32'h0001_0104, 0, 0, "R4 R10");       // first load misses
      for (int k = 0; k < 4; k++) req(0, 2'd0, 32'h0001_0108 + k, 0, 0, "R1 R2");
      req(0, 2'd1, 32'h0001_010A, 0, 0, "R1 R2");
      req(0, 2'd1, 32'h0001_0108, 0, 0, "R1 R2");
      req(0, 2'd2, 32'h0001_0110, 0, 0, "R1 R2");
      req(1, 2'd0, 32'h0001_0109, 32'hFFFF_FFA5, 0, "R3 R6");
      req(0, 2'd2, 32'h0001_0108, 0, 0, "R3");
      req(1, 2'd1, 32'h0001_010E, 32'h1234_BEEF, 0, "R3 R6");
      req(0, 2'd2, 32'h0001_010C, 0, 0, "R3");
      lat = 2;
      req(1, 2'd2, 32'h0001_2100, 32'hCAFE_F00D, 0, "R6");  // store miss
      req(0, 2'd2, 32'h0001_2100, 0, 0, "R6");              // no allocate: miss
      req(0, 2'd2, 32'h0001_4200, 0, 1, "R5");              // bypass load
      req(0, 2'd2, 32'h0001_4200, 0, 0, "R5");              // still misses
      req(0, 2'd2, 32'h0001_2104, 0, 0, "R4");              // same index other tag
      req(0, 2'd2, 32'h0001_0104, 0, 0, "R4");
      req(0, 2'd1, 32'h0001_0101, 0, 0, "R8");
      req(0, 2'd2, 32'h0001_0102, 0, 0, "R8");
      req(1, 2'd3, 32'h0001_0100, 32'h0, 0, "R8");
      req(1, 2'd2, 32'h0001_0106, 32'hDEAD_DEAD, 0, "R8");
      req(0, 2'd2, 32'h0001_0104, 0, 0, "R8");
      do_flush();
      req(0, 2'd2, 32'h0001_0104, 0, 0, "R9");
      req(1, 2'd0, 32'h8000_0011, 32'h77, 1, "R5 R6");
      req(0, 2'd2, 32'h8000_0010, 0, 1, "R5");
      lat = 3;
      req(0, 2'd0, 32'h0001_301F, 0, 0, "R4 R2");           // target is last beat

      for (int n = 0; n < 300; n++) begin
         logic [31:0] a;
         logic [1:0]  sz;
         bit          we, inh;
         seed = seed * 32'd1103515245 + 32'd12345;
         we  = seed[16];
         sz  = seed[18:17];
         inh = (seed[21:19] == 3'd0);
         a   = 32'h0001_0000 | {17'b0, seed[23:22], 8'b0, seed[25:24], seed[28:26], seed[30:29]};
         if (seed[31] || seed[15]) begin
            if (sz == 2'd1) a[0] = 1'b0;
            if (sz >= 2'd2) begin a[1:0] = 2'd0; if (sz == 2'd3) sz = 2'd2; end
         end
         if (inh && we) a = a | 32'h8000_0000;
         lat = 1 + int'(seed[14:13]) % 3;
         if (seed[12:8] == 5'd0) do_flush();
         req(we, sz, a, seed ^ 32'h5A5A_A5A5, inh,
             we ? "R3 R6" : (inh ? "R5" : "R1 R2 R4"));
      end
      while (busy) step();
      repeat (3) step();
      done = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule